// File: doc/BRIEF.md
# Sixteen-Bit Timer/Counter with Selectable Wrap Point

This block is a 16-bit up-counter that advances by one on every clock cycle where its count-enable input is high and freezes otherwise, so an external clock-select or prescaler stage decides its pace. A 3-bit mode input picks the wrap point (TOP): the full 16-bit range, one of three fixed widths, the active value of compare channel A, or a capture-register value supplied from outside. When the count has reached TOP, the next enabled tick returns it to zero and a one-cycle overflow strobe marks the wrap.

Two compare channels watch the counter at all times. Each has a write buffer and an active register. In the free-running modes a write reaches the active register at once. In the PWM modes it waits in the buffer until the counter wraps, so that a period or duty change never lands in the middle of a cycle. Each channel keeps a sticky match flag that is cleared by writing a one, and drives a PWM level that is high while the count is below its active compare value. When channel A supplies TOP, its PWM output is forced low. Taking TOP from the capture value leaves channel A free for PWM.

Top module: `tmr16_core`

## Requirements
- R1: With `tick_en` low the count holds its value; with `tick_en` high and the count below TOP it rises by exactly one on the next clock.
- R2: `at_bottom` is high exactly when the count is 0x0000, `at_max` exactly when it is 0xFFFF, and `at_top` exactly when it equals the current TOP.
- R3: TOP follows `mode`: 0 gives 0xFFFF, 1 gives 0x00FF, 2 gives 0x01FF, 3 gives 0x03FF, 4 gives channel A's active compare value, 5 gives `cap_val`; codes 6 and 7 act like code 0.
- R4: An enabled tick with the count at or above TOP makes the count 0x0000 on the next clock.
- R5: `ovf_strb` is high for the single cycle after each wrap edge, and low after every clock edge with no wrap.
- R6: An enabled tick with the count equal to channel i's active compare value sets `match_flag[i]` (bit 0 = channel A, bit 1 = channel B) on the next clock, and the flag stays set.
- R7: A one in `flag_clr[i]` clears `match_flag[i]` on the next clock, unless a match on that channel happens in the same cycle, in which case the flag stays set.
- R8: In modes 0, 6 and 7, a write (`cmp_wr[i]` high with data on `cmp_wdata`) updates channel i's active compare value on the next clock.
- R9: In modes 1 to 5 a write only fills channel i's buffer, and the active value takes the buffer contents at the next wrap edge; in mode 4 this is what makes TOP double-buffered.
- R10: In modes 1 to 5, `pwm_out[i]` is high while the count is below channel i's active compare value; it is always low in modes 0, 6 and 7, and `pwm_out[0]` is low in mode 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable from clock select |
| mode | input | 3 | Wrap-point and update mode |
| cmp_wr | input | 2 | Per-channel compare write strobe (bit 0 = A) |
| cmp_wdata | input | 16 | Compare write data shared by both channels |
| cap_val | input | 16 | Capture-register value used as TOP in mode 5 |
| flag_clr | input | 2 | Write-one-to-clear for the match flags |
| count | output | 16 | Counter value |
| at_bottom | output | 1 | Count is 0x0000 |
| at_top | output | 1 | Count equals TOP |
| at_max | output | 1 | Count is 0xFFFF |
| ovf_strb | output | 1 | One-cycle wrap strobe |
| match_flag | output | 2 | Sticky compare-match flags |
| pwm_out | output | 2 | Per-channel PWM level |

## Verification
The hardest case to reach from the ports is a compare write that arrives in the middle of a PWM period. Its effect must stay hidden until the counter wraps, and the only evidence is the PWM level and the match timing some cycles later. The stimulus sets a known compare value in a free-running mode, switches to an 8-bit PWM mode, and writes a new value partway through the period. It then samples `pwm_out[0]` at a count that lies between the old and new values, once before the wrap and once after. Reaching 0xFFFF also needs a dedicated uninterrupted 65536-tick run in mode 0, since the random phases of enabled ticks never climb that far.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  localparam int unsigned TMR_W  = 16;
  localparam int unsigned NCH    = 2;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_FREE       = 3'd0,
    MD_PWM_8      = 3'd1,
    MD_PWM_9      = 3'd2,
    MD_PWM_10     = 3'd3,
    MD_PWM_TOPA   = 3'd4,
    MD_PWM_TOPCAP = 3'd5,
    MD_RSV6       = 3'd6,
    MD_RSV7       = 3'd7
  } tmr_mode_e;

  // Modes whose compare writes are buffered until the wrap
  function automatic logic mode_is_pwm(input logic [MODE_W-1:0] m);
    return (m >= MD_PWM_8) && (m <= MD_PWM_TOPCAP);
  endfunction

  // Mode in which channel A defines the wrap point
  function automatic logic mode_a_is_top(input logic [MODE_W-1:0] m);
    return m == MD_PWM_TOPA;
  endfunction

endpackage

// File: rtl/tmr16_top_sel.sv
module tmr16_top_sel
  import tmr16_pkg::*;
#(
  parameter int unsigned W = TMR_W
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [W-1:0]      ocra_act,
  input  logic [W-1:0]      cap_val,
  output logic [W-1:0]      top_val,
  output logic              is_pwm,
  output logic              a_is_top
);

  localparam logic [W-1:0] TOP_8  = {{(W-8){1'b0}},  {8{1'b1}}};
  localparam logic [W-1:0] TOP_9  = {{(W-9){1'b0}},  {9{1'b1}}};
  localparam logic [W-1:0] TOP_10 = {{(W-10){1'b0}}, {10{1'b1}}};
  localparam logic [W-1:0] TOP_MAX = {W{1'b1}};

  function automatic logic [W-1:0] pick_top(input logic [MODE_W-1:0] m,
                                            input logic [W-1:0] a,
                                            input logic [W-1:0] c);
    case (tmr_mode_e'(m))
      MD_PWM_8:      return TOP_8;
      MD_PWM_9:      return TOP_9;
      MD_PWM_10:     return TOP_10;
      MD_PWM_TOPA:   return a;
      MD_PWM_TOPCAP: return c;
      default:       return TOP_MAX;
    endcase
  endfunction

  assign top_val  = pick_top(mode, ocra_act, cap_val);
  assign is_pwm   = mode_is_pwm(mode);
  assign a_is_top = mode_a_is_top(mode);

endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter
  import tmr16_pkg::*;
#(
  parameter int unsigned W = TMR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] count,
  output logic         wrap_evt,
  output logic         ovf_q
);

  // At or past the wrap point the next tick returns to zero
  function automatic logic [W-1:0] next_count(input logic [W-1:0] c,
                                              input logic [W-1:0] t);
    return (c >= t) ? '0 : c + 1'b1;
  endfunction

  assign wrap_evt = tick_en && (count >= top_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= wrap_evt;
      if (tick_en) count <= next_count(count, top_val);
    end
  end

endmodule

// File: rtl/tmr16_cmp_chan.sv
module tmr16_cmp_chan
  import tmr16_pkg::*;
#(
  parameter int unsigned W = TMR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         buffered,
  input  logic         wrap_evt,
  input  logic         tick_en,
  input  logic [W-1:0] count,
  input  logic         clr,
  input  logic         pwm_en,
  output logic [W-1:0] ocr_act,
  output logic         match_evt,
  output logic         flag,
  output logic         pwm
);

  logic [W-1:0] ocr_buf;

  function automatic logic pwm_level(input logic en,
                                     input logic [W-1:0] c,
                                     input logic [W-1:0] cmp);
    return en && (c < cmp);
  endfunction

  assign match_evt = tick_en && (count == ocr_act);
  assign pwm       = pwm_level(pwm_en, count, ocr_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ocr_buf <= '0;
      ocr_act <= '0;
      flag    <= 1'b0;
    end else begin
      if (wr) ocr_buf <= wdata;
      if (!buffered && wr)       ocr_act <= wdata;
      else if (buffered && wrap_evt) ocr_act <= ocr_buf;
      // a match in the same cycle outranks the clear
      flag <= match_evt || (flag && !clr);
    end
  end

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int unsigned W  = TMR_W,
  parameter int unsigned NC = NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [MODE_W-1:0] mode,
  input  logic [NC-1:0]     cmp_wr,
  input  logic [W-1:0]      cmp_wdata,
  input  logic [W-1:0]      cap_val,
  input  logic [NC-1:0]     flag_clr,
  output logic [W-1:0]      count,
  output logic              at_bottom,
  output logic              at_top,
  output logic              at_max,
  output logic              ovf_strb,
  output logic [NC-1:0]     match_flag,
  output logic [NC-1:0]     pwm_out
);

  // Named internal events, brought out for the checker
  logic [W-1:0]         top_val;
  logic                 wrap_evt;
  logic                 is_pwm;
  logic                 a_is_top;
  logic [NC-1:0]        match_evt;
  logic [NC-1:0]        pwm_en;
  logic [NC-1:0][W-1:0] act_vec;

  tmr16_top_sel #(.W(W)) u_top_sel (
    .mode     (mode),
    .ocra_act (act_vec[0]),
    .cap_val  (cap_val),
    .top_val  (top_val),
    .is_pwm   (is_pwm),
    .a_is_top (a_is_top)
  );

  tmr16_counter #(.W(W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .top_val  (top_val),
    .count    (count),
    .wrap_evt (wrap_evt),
    .ovf_q    (ovf_strb)
  );

  for (genvar g = 0; g < NC; g++) begin : g_ch
    if (g == 0) begin : g_a
      assign pwm_en[g] = is_pwm && !a_is_top;
    end else begin : g_other
      assign pwm_en[g] = is_pwm;
    end

    tmr16_cmp_chan #(.W(W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (cmp_wr[g]),
      .wdata     (cmp_wdata),
      .buffered  (is_pwm),
      .wrap_evt  (wrap_evt),
      .tick_en   (tick_en),
      .count     (count),
      .clr       (flag_clr[g]),
      .pwm_en    (pwm_en[g]),
      .ocr_act   (act_vec[g]),
      .match_evt (match_evt[g]),
      .flag      (match_flag[g]),
      .pwm       (pwm_out[g])
    );
  end

  assign at_bottom = (count == '0);
  assign at_max    = &count;
  assign at_top    = (count == top_val);

endmodule

// File: rtl/tmr16_core_chk.sv
module tmr16_core_chk
  import tmr16_pkg::*;
#(
  parameter int unsigned W  = TMR_W,
  parameter int unsigned NC = NCH
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick_en,
  input logic [MODE_W-1:0]    mode,
  input logic [NC-1:0]        cmp_wr,
  input logic [W-1:0]         cmp_wdata,
  input logic [NC-1:0]        flag_clr,
  input logic [W-1:0]         count,
  input logic [W-1:0]         top_val,
  input logic                 wrap_evt,
  input logic                 ovf_strb,
  input logic                 at_bottom,
  input logic [NC-1:0]        match_evt,
  input logic [NC-1:0]        match_flag,
  input logic [NC-1:0]        pwm_out,
  input logic [NC-1:0][W-1:0] act_vec
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(count));

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && count < top_val) |=> (count == $past(count) + ONE));

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (count == '0));

  a_r5_ovf_on: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_strb);

  a_r5_ovf_off: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> !ovf_strb);

  a_r5_ovf_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_strb |-> at_bottom);

  a_r10_topa_off: assert property (@(posedge clk) disable iff (!rst_n)
    mode_a_is_top(mode) |-> !pwm_out[0]);

  a_r10_free_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_is_pwm(mode) |-> (pwm_out == '0));

  for (genvar g = 0; g < NC; g++) begin : g_ch
    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt[g] |=> match_flag[g]);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[g] && !match_evt[g]) |=> !match_flag[g]);

    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_is_pwm(mode) && cmp_wr[g]) |=> (act_vec[g] == $past(cmp_wdata)));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_is_pwm(mode) && !wrap_evt) |=> $stable(act_vec[g]));
  end

endmodule

bind tmr16_core tmr16_core_chk #(.W(W), .NC(NC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .mode       (mode),
  .cmp_wr     (cmp_wr),
  .cmp_wdata  (cmp_wdata),
  .flag_clr   (flag_clr),
  .count      (count),
  .top_val    (top_val),
  .wrap_evt   (wrap_evt),
  .ovf_strb   (ovf_strb),
  .at_bottom  (at_bottom),
  .match_evt  (match_evt),
  .match_flag (match_flag),
  .pwm_out    (pwm_out),
  .act_vec    (act_vec)
);

// File: tb/tmr16_core_bench.sv
module tmr16_core_bench;

  localparam int PERIOD = 10;
  localparam int WATCHDOG_CYC = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [1:0]  cmp_wr = 2'b00;
  logic [15:0] cmp_wdata = 16'h0;
  logic [15:0] cap_val = 16'h0;
  logic [1:0]  flag_clr = 2'b00;
  logic [15:0] count;
  logic        at_bottom, at_top, at_max, ovf_strb;
  logic [1:0]  match_flag, pwm_out;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  logic [15:0] m_cnt;
  logic [15:0] m_buf [2];
  logic [15:0] m_act [2];
  logic [1:0]  m_flag;
  logic        m_ovf;

  tmr16_core u_tmr16_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode(mode),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cap_val(cap_val),
    .flag_clr(flag_clr), .count(count), .at_bottom(at_bottom),
    .at_top(at_top), .at_max(at_max), .ovf_strb(ovf_strb),
    .match_flag(match_flag), .pwm_out(pwm_out)
  );

  always #(PERIOD/2) clk = ~clk;

  // fixed widths as 2^n - 1, other tops by source
  function automatic logic [15:0] f_top(input logic [2:0] md,
                                        input logic [15:0] a,
                                        input logic [15:0] c);
    if (md >= 3'd1 && md <= 3'd3) return 16'((32'd1 << (32'(md) + 7)) - 32'd1);
    if (md == 3'd4) return a;
    if (md == 3'd5) return c;
    return 16'hFFFF;
  endfunction

  function automatic bit f_buffered(input logic [2:0] md);
    return md inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one clock: predict, advance, compare
  task automatic do_cycle();
    logic [15:0] tp;
    bit wrap;
    logic [15:0] n_buf [2];
    logic [15:0] n_act [2];
    logic [1:0]  n_flag;
    logic [1:0]  exp_pwm;
    tp   = f_top(mode, m_act[0], cap_val);
    wrap = tick_en && (m_cnt >= tp);
    for (int i = 0; i < 2; i++) begin
      bit mev;
      mev = tick_en && (m_cnt == m_act[i]);
      n_flag[i] = mev | (m_flag[i] & ~flag_clr[i]);
      n_buf[i]  = cmp_wr[i] ? cmp_wdata : m_buf[i];
      if (!f_buffered(mode)) n_act[i] = cmp_wr[i] ? cmp_wdata : m_act[i];
      else                   n_act[i] = wrap ? m_buf[i] : m_act[i];
    end
    @(posedge clk);
    #1;
    if (tick_en) m_cnt = wrap ? 16'h0 : m_cnt + 16'd1;
    m_ovf  = wrap;
    m_flag = n_flag;
    m_buf  = n_buf;
    m_act  = n_act;
    chk("R1/R4 count", count, m_cnt);
    chk("R5 ovf_strb", ovf_strb, m_ovf);
    chk("R6/R7 match_flag", match_flag, m_flag);
    for (int i = 0; i < 2; i++)
      exp_pwm[i] = f_buffered(mode) && !(i == 0 && mode == 3'd4) && (m_cnt < m_act[i]);
    chk("R10 pwm_out", pwm_out, exp_pwm);
    tp = f_top(mode, m_act[0], cap_val);
    chk("R2/R3 status", {at_bottom, at_top, at_max},
        {m_cnt == 16'h0, m_cnt == tp, m_cnt == 16'hFFFF});
    cmp_wr   = 2'b00;
    flag_clr = 2'b00;
  endtask

  task automatic tick_until(input logic [15:0] target);
    tick_en = 1'b1;
    while (m_cnt != target) do_cycle();
  endtask

  task automatic write_cmp(input logic [1:0] which, input logic [15:0] val, input bit tk);
    cmp_wr = which; cmp_wdata = val; tick_en = tk;
    do_cycle();
  endtask

  task automatic random_phase(input logic [2:0] md, input int cycles);
    mode = md;
    cap_val = 16'($urandom % 32'h400);
    for (int k = 0; k < cycles; k++) begin
      tick_en  = ($urandom % 4) != 0;
      cmp_wr   = (($urandom % 16) == 0) ? 2'($urandom % 4) : 2'b00;
      cmp_wdata = 16'($urandom % 32'h400);
      flag_clr = (($urandom % 8) == 0) ? 2'($urandom % 4) : 2'b00;
      do_cycle();
    end
  endtask

  initial begin
    #(PERIOD * WATCHDOG_CYC);
    n_fail++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", n_chk, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0615));
    m_cnt = 0; m_buf[0] = 0; m_buf[1] = 0; m_act[0] = 0; m_act[1] = 0;
    m_flag = 0; m_ovf = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state (R2, R5, R6)
    chk("R1 reset count", count, 16'h0);
    chk("R2 reset at_bottom", at_bottom, 1'b1);
    chk("R5 reset ovf_strb", ovf_strb, 1'b0);
    chk("R6 reset match_flag", match_flag, 2'b00);

    // R1: hold with enable low
    tick_en = 1'b0;
    repeat (4) do_cycle();
    chk("R1 hold without tick", count, 16'h0);

    // R8: immediate load in free mode, then matches at 3 and 5
    write_cmp(2'b01, 16'h0005, 1'b0);
    write_cmp(2'b10, 16'h0003, 1'b0);
    tick_en = 1'b1;
    repeat (8) do_cycle();
    chk("R8/R6 immediate compare flags", match_flag, 2'b11);

    // R7: clear
    tick_en = 1'b0; flag_clr = 2'b11;
    do_cycle();
    chk("R7 clear flags", match_flag, 2'b00);

    // R7: set wins over clear
    write_cmp(2'b10, m_cnt, 1'b0);
    tick_en = 1'b1; flag_clr = 2'b10;
    do_cycle();
    chk("R7 set wins over clear", match_flag[1], 1'b1);

    // R9: buffered compare write in 8-bit PWM
    write_cmp(2'b01, 16'h0040, 1'b0);
    mode = 3'd1;
    tick_until(16'h0050);
    write_cmp(2'b01, 16'h0080, 1'b1);
    tick_until(16'h0060);
    chk("R9 old compare kept before wrap", pwm_out[0], 1'b0);
    tick_until(16'h0000);
    tick_until(16'h0060);
    chk("R9 new compare after wrap", pwm_out[0], 1'b1);

    // R3: TOP from compare A (mode 4)
    mode = 3'd0;
    write_cmp(2'b01, 16'h0030, 1'b0);
    mode = 3'd4;
    tick_until(16'h0030);
    do_cycle();
    chk("R3 TOP from compare A", count, 16'h0);
    chk("R5 strobe at compare-A wrap", ovf_strb, 1'b1);
    chk("R10 channel A low when it is TOP", pwm_out[0], 1'b0);

    // R3: TOP from capture value (mode 5)
    mode = 3'd5; cap_val = 16'h0021;
    tick_until(16'h0021);
    do_cycle();
    chk("R3 TOP from capture value", count, 16'h0);

    // random phases across modes
    random_phase(3'd1, 2500);
    random_phase(3'd2, 2500);
    random_phase(3'd3, 2500);
    random_phase(3'd4, 2500);
    random_phase(3'd5, 2500);
    random_phase(3'd6, 1500);

    // R2/R4: full free-running pass to MAX
    mode = 3'd0; flag_clr = 2'b00; cmp_wr = 2'b00;
    tick_until(16'hFFFF);
    chk("R2 at_max at 0xFFFF", at_max, 1'b1);
    do_cycle();
    chk("R4 wrap after MAX", count, 16'h0);
    chk("R5 strobe after MAX", ovf_strb, 1'b1);
    tick_en = 1'b1;
    do_cycle();
    chk("R5 strobe lasts one cycle", ovf_strb, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule